// File: doc/BRIEF.md
# Iterative AES-128 Encryption Core

This block encrypts 128-bit data blocks under a 128-bit key with AES-128. It executes one round per clock cycle in a single reusable round datapath. The tenth round, which has no column mixing, passes through that same datapath. Each new round key is derived from the previous one in the same cycle as the state update, so the expanded key is never stored.

A plaintext block and its key enter together through a valid/ready handshake, and the ciphertext leaves through its own valid/ready handshake. The finished ciphertext sits in a dedicated output register. Because of this, the next block can be loaded during the final round of the current one, and a continuous stream produces one ciphertext every ten cycles. If the consumer stalls, the result is held and new input is refused until the result is taken.

Top module: `aes128_stream_enc`

## Requirements
- R1: After reset, and in any cycle with no block in flight and no pending result, `out_valid` is 0 and `in_ready` is 1.
- R2: The ciphertext equals standard AES-128 encryption of `in_pt` under `in_key`. Bit 127..120 of each 128-bit bus is byte 0, and bytes fill the state column by column, top to bottom.
- R3: A block accepted at clock edge k shows its ciphertext with `out_valid` high right after edge k+10, which is the 11th cycle counting the handshake cycle as the first.
- R4: During a block's final round `in_ready` is high. A continuous stream is therefore accepted every 10 cycles and produces results 10 cycles apart.
- R5: For the nine cycles after an input handshake, `in_ready` is low, and `in_valid`, `in_key` and `in_pt` have no effect on any result.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged.
- R7: While a result is pending, a block that has reached its final round waits there and `in_ready` is low. When `out_ready` rises, the waiting block's ciphertext replaces the old one in the following cycle.
- R8: Each block uses the key presented with it, so successive blocks may use different keys.
- R9: The round constant takes the values 01,02,04,08,10,20,40,80,1b,36 in rounds 1 to 10. Each value after the first is the previous one doubled in GF(2^8) modulo 0x11B.
- R10: Asserting `rst_n` low during a block discards that block. No result for it appears later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input block and key are presented |
| in_ready | output | 1 | Core can take a block this cycle |
| in_key | input | 128 | Cipher key for the presented block |
| in_pt | input | 128 | Plaintext block |
| out_valid | output | 1 | Ciphertext is available |
| out_ready | input | 1 | Consumer takes the ciphertext this cycle |
| out_data | output | 128 | Ciphertext block |

## Verification
The bench drives junk on the input while a block is mid-rounds. A core that raised `in_ready` early would then corrupt or replace the known-answer result. It stalls the output with a second block already in its final round. A core that let that round retire would overwrite the pending ciphertext, and one that stalled too little would lose the first result. A continuous five-block stream is timed edge by edge, so an extra set-up cycle per block shows up as 11- or 12-cycle spacing. A reset in mid-block checks that no stale ciphertext comes out afterwards.

// File: rtl/aes128_enc_pkg.sv
package aes128_enc_pkg;

    localparam int BLK_W   = 128;
    localparam int BYTES   = BLK_W / 8;
    localparam int WORDS   = BLK_W / 32;
    localparam int N_RND   = 10;
    localparam int RND_W   = $clog2(N_RND + 1);

    typedef struct packed {
        logic             busy;
        logic [RND_W-1:0] rnd;
        logic [7:0]       rcon;
        logic [BLK_W-1:0] st;
        logic [BLK_W-1:0] rk;
        logic             ovld;
        logic [BLK_W-1:0] odat;
    } core_t;

    function automatic logic [7:0] gf_dbl(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_dbl(sh);
        end
        return acc;
    endfunction

    // multiplicative inverse as x^254 (zero maps to zero)
    function automatic logic [7:0] gf_inv(input logic [7:0] x);
        logic [7:0] r;
        logic [7:0] b;
        r = 8'h01;
        b = x;
        for (int i = 0; i < 8; i++) begin
            if (i != 0) r = gf_mul(r, b);
            b = gf_mul(b, b);
        end
        return r;
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] v, input int k);
        logic [15:0] w;
        w = {v, v} << k;
        return w[15:8];
    endfunction

    function automatic logic [7:0] sbox_calc(input logic [7:0] x);
        logic [7:0] v;
        v = gf_inv(x);
        return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
    endfunction

endpackage

// File: rtl/aes128_sbox.sv
module aes128_sbox (
    input  logic [7:0] x,
    output logic [7:0] y
);
    import aes128_enc_pkg::*;

    always_comb begin
        y = sbox_calc(x);
    end
endmodule

// File: rtl/aes128_key_next.sv
module aes128_key_next
    import aes128_enc_pkg::*;
(
    input  logic [BLK_W-1:0] key_i,
    input  logic [7:0]       rcon_i,
    output logic [BLK_W-1:0] key_o
);
    logic [31:0] w   [WORDS];
    logic [31:0] nw  [WORDS];
    logic [31:0] rot;
    logic [31:0] sub;

    always_comb begin
        for (int i = 0; i < WORDS; i++) begin
            w[i] = key_i[BLK_W-1-32*i -: 32];
        end
        rot = {w[WORDS-1][23:0], w[WORDS-1][31:24]};
    end

    for (genvar gb = 0; gb < 4; gb++) begin : g_ksub
        aes128_sbox u_sb (
            .x (rot[31-8*gb -: 8]),
            .y (sub[31-8*gb -: 8])
        );
    end

    always_comb begin
        nw[0] = w[0] ^ sub ^ {rcon_i, 24'h000000};
        for (int i = 1; i < WORDS; i++) begin
            nw[i] = w[i] ^ nw[i-1];
        end
        for (int i = 0; i < WORDS; i++) begin
            key_o[BLK_W-1-32*i -: 32] = nw[i];
        end
    end
endmodule

// File: rtl/aes128_round_fn.sv
module aes128_round_fn
    import aes128_enc_pkg::*;
(
    input  logic [BLK_W-1:0] st_i,
    input  logic             last_i,
    output logic [BLK_W-1:0] st_o
);
    logic [7:0] sb [BYTES];
    logic [7:0] sr [BYTES];
    logic [7:0] a0, a1, a2, a3;
    logic [7:0] mc [BYTES];

    for (genvar gi = 0; gi < BYTES; gi++) begin : g_sub
        aes128_sbox u_sb (
            .x (st_i[BLK_W-1-8*gi -: 8]),
            .y (sb[gi])
        );
    end

    always_comb begin
        a0 = 8'h00;
        a1 = 8'h00;
        a2 = 8'h00;
        a3 = 8'h00;
        // row r of column c takes the byte from column c+r of the same row
        for (int c = 0; c < 4; c++) begin
            for (int r = 0; r < 4; r++) begin
                sr[4*c+r] = sb[4*((c+r)%4)+r];
            end
        end
        for (int c = 0; c < 4; c++) begin
            a0 = sr[4*c];
            a1 = sr[4*c+1];
            a2 = sr[4*c+2];
            a3 = sr[4*c+3];
            mc[4*c]   = gf_dbl(a0) ^ gf_dbl(a1) ^ a1 ^ a2 ^ a3;
            mc[4*c+1] = a0 ^ gf_dbl(a1) ^ gf_dbl(a2) ^ a2 ^ a3;
            mc[4*c+2] = a0 ^ a1 ^ gf_dbl(a2) ^ gf_dbl(a3) ^ a3;
            mc[4*c+3] = gf_dbl(a0) ^ a0 ^ a1 ^ a2 ^ gf_dbl(a3);
        end
        for (int i = 0; i < BYTES; i++) begin
            st_o[BLK_W-1-8*i -: 8] = last_i ? sr[i] : mc[i];
        end
    end
endmodule

// File: rtl/aes128_stream_enc.sv
module aes128_stream_enc
    import aes128_enc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [BLK_W-1:0] in_key,
    input  logic [BLK_W-1:0] in_pt,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [BLK_W-1:0] out_data
);
    localparam logic [RND_W-1:0] LAST_RND  = RND_W'(N_RND);
    localparam logic [RND_W-1:0] FIRST_RND = RND_W'(1);

    core_t q, d;

    logic             at_last;
    logic             fire_last;
    logic             sink_free;
    logic             accept;
    logic [BLK_W-1:0] key_nx;
    logic [BLK_W-1:0] rnd_nx;

    aes128_key_next u_key (
        .key_i  (q.rk),
        .rcon_i (q.rcon),
        .key_o  (key_nx)
    );

    aes128_round_fn u_rnd (
        .st_i   (q.st),
        .last_i (at_last),
        .st_o   (rnd_nx)
    );

    always_comb begin
        at_last   = q.busy && (q.rnd == LAST_RND);
        sink_free = !q.ovld || out_ready;
        fire_last = at_last && sink_free;
        in_ready  = (!q.busy || fire_last) && sink_free;
        accept    = in_valid && in_ready;

        d = q;
        if (q.ovld && out_ready) d.ovld = 1'b0;
        if (q.busy) begin
            if (!at_last) begin
                d.st   = rnd_nx ^ key_nx;
                d.rk   = key_nx;
                d.rcon = gf_dbl(q.rcon);
                d.rnd  = q.rnd + 1'b1;
            end else if (fire_last) begin
                d.odat = rnd_nx ^ key_nx;
                d.ovld = 1'b1;
                d.busy = 1'b0;
            end
        end
        if (accept) begin
            d.busy = 1'b1;
            d.rnd  = FIRST_RND;
            d.rcon = 8'h01;
            d.st   = in_pt ^ in_key;
            d.rk   = in_key;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_valid = q.ovld;
    assign out_data  = q.odat;

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R5
    accept_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R3
    out_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(q.busy && q.rnd == LAST_RND));

    // R9
    rcon_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> ($countones(q.rcon) == 1 || q.rcon == 8'h1b || q.rcon == 8'h36));

    // R4
    round_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> (q.rnd >= FIRST_RND && q.rnd <= LAST_RND));

    // R9
    rcon_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.rnd != LAST_RND && !(in_valid && in_ready)) |=> (q.rcon == gf_dbl($past(q.rcon))));
endmodule

// File: tb/aes128_stream_enc_test.sv
`timescale 1ns/1ps
module aes128_stream_enc_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_key = '0;
    logic [127:0] in_pt = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [127:0] out_data;

    always #2.5 clk = ~clk;

    aes128_stream_enc uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_key    (in_key),
        .in_pt     (in_pt),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    // {key, plaintext, ciphertext}
    localparam int NV = 5;
    localparam logic [383:0] VECS [NV] = '{
        {128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff, 128'h69c4e0d86a7b0430d8cdb78070b4c55a},
        {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3243f6a8885a308d313198a2e0370734, 128'h3925841d02dc09fbdc118597196a0b32},
        {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h6bc1bee22e409f96e93d7e117393172a, 128'h3ad77bb40d7a3660a89ecaf32466ef97},
        {128'h00000000000000000000000000000000, 128'h00000000000000000000000000000000, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e},
        {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'hae2d8a571e03ac9c9eb76fac45af8e51, 128'hf5d3d58503b9699de785895a96fdbaaf}
    };

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one block with the consumer always ready; junk on the input while busy
    task automatic run_single(input int i);
        @(negedge clk);
        out_ready = 1'b1;
        in_valid  = 1'b1;
        in_key    = VECS[i][383:256];
        in_pt     = VECS[i][255:128];
        chk(in_ready, "R1 idle in_ready", 128'(in_ready), 128'd1);
        @(posedge clk);
        @(negedge clk);
        in_key = ~VECS[i][383:256];
        in_pt  = ~VECS[i][255:128];
        for (int j = 0; j <= 10; j++) begin
            if (j > 0) @(negedge clk);
            if (j <= 8) chk(!in_ready, "R5 busy in_ready", 128'(in_ready), 128'd0);
            if (j == 8) in_valid = 1'b0;
            if (j < 10) begin
                chk(!out_valid, "R3 early out_valid", 128'(out_valid), 128'd0);
            end else begin
                chk(out_valid, "R3 out_valid at 11th cycle", 128'(out_valid), 128'd1);
                chk(out_data == VECS[i][127:0], "R2 R8 ciphertext", out_data, VECS[i][127:0]);
            end
        end
        @(negedge clk);
        chk(!out_valid, "R1 out_valid after handshake", 128'(out_valid), 128'd0);
    endtask

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int acc_cyc [NV];
        int out_cyc [NV];
        int in_idx;
        int out_idx;
        int guard;
        bit t;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!out_valid, "R1 reset out_valid", 128'(out_valid), 128'd0);
        chk(in_ready, "R1 reset in_ready", 128'(in_ready), 128'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready && !out_valid, "R1 after reset release", {out_valid, in_ready}, 128'd1);

        // table walk, one block at a time
        for (int i = 0; i < NV; i++) run_single(i);

        // continuous stream
        in_idx  = 0;
        out_idx = 0;
        guard   = 0;
        out_ready = 1'b1;
        while (out_idx < NV && guard < 300) begin
            guard++;
            @(negedge clk);
            if (out_valid) begin
                chk(out_data == VECS[out_idx][127:0], "R2 R4 stream data", out_data, VECS[out_idx][127:0]);
                out_cyc[out_idx] = cyc;
                out_idx++;
            end
            if (in_idx < NV) begin
                in_valid = 1'b1;
                in_key   = VECS[in_idx][383:256];
                in_pt    = VECS[in_idx][255:128];
            end else begin
                in_valid = 1'b0;
            end
            #0.5;
            if (in_valid && in_ready) begin
                acc_cyc[in_idx] = cyc;
                in_idx++;
            end
        end
        chk(out_idx == NV, "R4 stream complete", 128'(out_idx), 128'(NV));
        chk(out_cyc[0] - acc_cyc[0] == 11, "R3 stream latency", 128'(out_cyc[0] - acc_cyc[0]), 128'd11);
        for (int i = 1; i < NV; i++) begin
            chk(acc_cyc[i] - acc_cyc[i-1] == 10, "R4 accept spacing", 128'(acc_cyc[i] - acc_cyc[i-1]), 128'd10);
            chk(out_cyc[i] - out_cyc[i-1] == 10, "R4 output spacing", 128'(out_cyc[i] - out_cyc[i-1]), 128'd10);
        end

        // output stall with a second block waiting in its final round
        @(negedge clk);
        out_ready = 1'b0;
        in_valid  = 1'b1;
        in_key    = VECS[1][383:256];
        in_pt     = VECS[1][255:128];
        @(posedge clk);
        @(negedge clk);
        in_key = VECS[3][383:256];
        in_pt  = VECS[3][255:128];
        guard  = 0;
        t      = 1'b0;
        while (!t && guard < 30) begin
            guard++;
            #0.5;
            t = in_ready;
            @(posedge clk);
            @(negedge clk);
        end
        in_key = '1;
        in_pt  = '1;
        chk(out_valid && out_data == VECS[1][127:0], "R6 first result", out_data, VECS[1][127:0]);
        for (int j = 0; j < 20; j++) begin
            @(negedge clk);
            chk(out_valid, "R6 held valid", 128'(out_valid), 128'd1);
            chk(out_data == VECS[1][127:0], "R6 held data", out_data, VECS[1][127:0]);
            chk(!in_ready, "R7 no accept while pending", 128'(in_ready), 128'd0);
        end
        in_valid  = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        chk(out_valid && out_data == VECS[3][127:0], "R7 waiting block released", out_data, VECS[3][127:0]);
        @(negedge clk);
        chk(!out_valid, "R7 no extra result", 128'(out_valid), 128'd0);
        for (int j = 0; j < 12; j++) begin
            @(negedge clk);
            chk(!out_valid, "R5 R7 junk ignored", 128'(out_valid), 128'd0);
        end

        // reset in the middle of a block
        @(negedge clk);
        in_valid = 1'b1;
        in_key   = VECS[2][383:256];
        in_pt    = VECS[2][255:128];
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        #0.5;
        chk(!out_valid && in_ready, "R10 R1 reset mid block", {out_valid, in_ready}, 128'd1);
        @(negedge clk);
        rst_n = 1'b1;
        for (int j = 0; j < 14; j++) begin
            @(negedge clk);
            chk(!out_valid, "R10 no stale result", 128'(out_valid), 128'd0);
        end
        run_single(0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule